// File: doc/BRIEF.md
# Pulse-Swallow Programmable RF Divider

This block divides an RF-rate clock by any integer from 240 to 32767 in steps of one, so a synthesiser loop built around it tunes in steps equal to its comparison frequency. It is organised as a dual-modulus prescaler that counts either 16 or 17 input cycles, followed by a 4-bit swallow counter and an 11-bit main counter. The 15-bit ratio word splits into a main count (upper 11 bits) and a swallow count (lower 4 bits). During each output cycle the prescaler runs at 17 for as many of its own cycles as the swallow count, and at 16 for the rest of the main count.

The control side writes a ratio and pulses a load strobe. The word is held in a shadow register and moves into the counters only when the current output cycle ends, so every output cycle has a single, whole ratio. Words below the smallest legal ratio are raised to it. The divider produces a one-clock pulse at the end of every output cycle for the phase detector, and a toggling output at half that rate for test observation.

Top module: `pswl_divider`

## Requirements
- R1: The distance between consecutive `div_pulse` pulses is 16·M + A clock cycles, where M = `ratio_in[14:4]` and A = `ratio_in[3:0]` of the word in force, for words from 240 to 32767.
- R2: A loaded word below 240 (including 0) behaves as 240, so the pulse distance becomes 240 cycles.
- R3: `div_pulse` is high for exactly one clock cycle per output cycle and low in the cycle after each pulse.
- R4: `div_half` inverts in the same cycle that `div_pulse` is high and holds its value in every other cycle.
- R5: A word loaded partway through an output cycle does not change that cycle: the pulse that ends it arrives as the old ratio dictates, and the new ratio governs the following cycle.
- R6: While `rst` is high both outputs are 0; after reset the divider runs at the `RESET_RATIO` parameter (default 1000), so the pulse distance is 1000 cycles until the first load.
- R7: When several loads arrive within one output cycle, the last one decides the ratio of the next cycle.
- R8: Within an output cycle the swallow count still to run never exceeds the main count still to run, and the word held in the shadow register never falls below 240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF-rate input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_in | input | 15 | Division ratio word, main count in bits 14:4, swallow count in bits 3:0 |
| ratio_load | input | 1 | Captures `ratio_in` into the shadow register on the clock edge where it is high |
| div_pulse | output | 1 | One-cycle pulse at the end of each output cycle |
| div_half | output | 1 | Toggles on each `div_pulse`, giving half the divided rate |

## Verification
The assertions take for granted that `ratio_load` and `ratio_in` are synchronous to `clk` and settle well before its rising edge, and that the ratio in force never drops under the floor, so pulses are always at least 239 idle cycles apart. They make no assumption about the word's value, since the shadow register raises low words itself. The stimulus changes inputs only on the falling edge, loads words both under and above the floor (0, 16, 100, 240, 255, 32767 and random values), and places every load a cycle or two after a pulse, so that the cycle in progress and the next one can each be timed on their own.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

    // Prescaler modulus selection: base count or base plus one.
    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } modsel_e;

    // Smallest ratio for which the main count is never below the swallow
    // count: main must reach the largest swallow value, (2^sw - 1).
    function automatic int unsigned floor_ratio(input int unsigned sw);
        return ((32'd1 << sw) - 32'd1) << sw;
    endfunction

endpackage

// File: rtl/pswl_prescaler.sv
module pswl_prescaler
    import pswl_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  modsel_e mode,
    output logic    tick
);
    localparam int CW = SW + 1;
    localparam logic [CW-1:0] LAST_BASE = CW'((1 << SW) - 1);
    localparam logic [CW-1:0] LAST_PLUS = CW'(1 << SW);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb last = (mode == MOD_PLUS1) ? LAST_PLUS : LAST_BASE;

    assign tick = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pswl_counters.sv
module pswl_counters
    import pswl_pkg::*;
#(
    parameter int SW    = 4,
    parameter int MW    = 11,
    parameter int RST_A = 8,
    parameter int RST_M = 62
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [SW-1:0] load_a,
    input  logic [MW-1:0] load_m,
    output modsel_e       mode,
    output logic          cycle_end,
    output logic [SW-1:0] a_rem,
    output logic [MW-1:0] m_rem
);
    localparam logic [MW-1:0] M_ONE = MW'(1);

    assign cycle_end = tick && (m_rem == M_ONE);
    assign mode      = (a_rem != '0) ? MOD_PLUS1 : MOD_BASE;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_rem <= SW'(RST_A);
            m_rem <= MW'(RST_M);
        end else if (cycle_end) begin
            a_rem <= load_a;
            m_rem <= load_m;
        end else if (tick) begin
            m_rem <= m_rem - 1'b1;
            if (a_rem != '0) a_rem <= a_rem - 1'b1;
        end
    end
endmodule

// File: rtl/pswl_ratio_shadow.sv
module pswl_ratio_shadow
    import pswl_pkg::*;
#(
    parameter int SW      = 4,
    parameter int MW      = 11,
    parameter int RST_EFF = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SW+MW-1:0] ratio_in,
    output logic [SW+MW-1:0] pend,
    output logic [SW-1:0]    load_a,
    output logic [MW-1:0]    load_m
);
    localparam int RW = SW + MW;
    localparam logic [RW-1:0] FLOOR = RW'(floor_ratio(SW));

    always_ff @(posedge clk) begin
        if (rst)       pend <= RW'(RST_EFF);
        else if (load) pend <= (ratio_in < FLOOR) ? FLOOR : ratio_in;
    end

    assign load_a = pend[SW-1:0];
    assign load_m = pend[RW-1:SW];
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider
    import pswl_pkg::*;
#(
    parameter int SW          = 4,
    parameter int MW          = 11,
    parameter int RESET_RATIO = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW+MW-1:0] ratio_in,
    input  logic             ratio_load,
    output logic             div_pulse,
    output logic             div_half
);
    localparam int RW      = SW + MW;
    localparam int FLOOR   = int'(floor_ratio(SW));
    localparam int RST_EFF = (RESET_RATIO < FLOOR) ? FLOOR : RESET_RATIO;
    localparam int RST_A   = RST_EFF % (1 << SW);
    localparam int RST_M   = RST_EFF >> SW;

    modsel_e       mode;
    logic          tick;
    logic          cycle_end;
    logic [SW-1:0] a_rem;
    logic [MW-1:0] m_rem;
    logic [SW-1:0] load_a;
    logic [MW-1:0] load_m;
    logic [RW-1:0] pend_ratio;

    pswl_ratio_shadow #(.SW(SW), .MW(MW), .RST_EFF(RST_EFF)) shadow_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ratio_load),
        .ratio_in (ratio_in),
        .pend     (pend_ratio),
        .load_a   (load_a),
        .load_m   (load_m)
    );

    pswl_prescaler #(.SW(SW)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .tick (tick)
    );

    pswl_counters #(.SW(SW), .MW(MW), .RST_A(RST_A), .RST_M(RST_M)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_a    (load_a),
        .load_m    (load_m),
        .mode      (mode),
        .cycle_end (cycle_end),
        .a_rem     (a_rem),
        .m_rem     (m_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_pulse <= 1'b0;
            div_half  <= 1'b0;
        end else begin
            div_pulse <= cycle_end;
            div_half  <= div_half ^ cycle_end;
        end
    end
endmodule

// File: rtl/pswl_checker.sv
module pswl_checker
    import pswl_pkg::*;
#(
    parameter int SW = 4,
    parameter int MW = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             div_pulse,
    input logic             div_half,
    input logic [SW-1:0]    a_rem,
    input logic [MW-1:0]    m_rem,
    input logic [SW+MW-1:0] pend_ratio
);
    localparam int RW    = SW + MW;
    localparam int FLOOR = int'(floor_ratio(SW));
    localparam int MAXR  = (1 << RW) - 1;

    int unsigned gap;

    always_ff @(posedge clk) begin
        if (rst)            gap <= 0;
        else if (div_pulse) gap <= 0;
        else                gap <= gap + 1;
    end

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    assert_half_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> (div_half != $past(div_half)));

    assert_half_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |-> $stable(div_half));

    assert_gap_min_R2: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> (gap >= FLOOR - 1));

    assert_gap_max_R1: assert property (@(posedge clk) disable iff (rst)
        gap <= MAXR + 1);

    assert_swallow_le_main_R8: assert property (@(posedge clk) disable iff (rst)
        32'(a_rem) <= 32'(m_rem));

    assert_shadow_floor_R8: assert property (@(posedge clk) disable iff (rst)
        32'(pend_ratio) >= FLOOR);
endmodule

bind pswl_divider pswl_checker #(.SW(SW), .MW(MW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .div_pulse  (div_pulse),
    .div_half   (div_half),
    .a_rem      (a_rem),
    .m_rem      (m_rem),
    .pend_ratio (pend_ratio)
);

// File: tb/pswl_divider_tb.sv
module pswl_divider_tb_top;
    localparam int N_VEC = 8;
    localparam logic [14:0] VEC_RATIO [N_VEC] = '{15'd240, 15'd32767, 15'd1000, 15'd4111,
                                                   15'd100, 15'd0,     15'd255,  15'd16};
    localparam int VEC_EXP [N_VEC] = '{240, 32767, 1000, 4111, 240, 240, 255, 240};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ratio_in = '0;
    logic        ratio_load = 1'b0;
    logic        div_pulse;
    logic        div_half;

    int checks = 0;
    int fails  = 0;
    int prev_n = 1000;

    always #2 clk = ~clk;

    pswl_divider dut_i (
        .clk        (clk),
        .rst        (rst),
        .ratio_in   (ratio_in),
        .ratio_load (ratio_load),
        .div_pulse  (div_pulse),
        .div_half   (div_half)
    );

    function automatic int model_period(input logic [14:0] r);
        int n;
        n = 16 * int'(r[14:4]) + int'(r[3:0]);
        return (n < 240) ? 240 : n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count falling edges up to and including the next one where the pulse is seen.
    task automatic wait_pulse(output int n);
        logic h0;
        h0 = div_half;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse && n < 40000);
        check(div_half != h0, "R4 half toggles on pulse", int'(div_half), int'(!h0));
    endtask

    // Called right after a pulse was sampled; uses two falling edges.
    task automatic apply_load(input logic [14:0] r);
        @(negedge clk);
        check(div_pulse == 1'b0, "R3 pulse one cycle wide", int'(div_pulse), 0);
        ratio_in   = r;
        ratio_load = 1'b1;
        @(negedge clk);
        ratio_load = 1'b0;
    endtask

    initial begin
        int n;
        int e;
        repeat (5) begin
            @(negedge clk);
            check(div_pulse == 1'b0 && div_half == 1'b0, "R6 outputs low in reset",
                  int'({div_pulse, div_half}), 0);
        end
        rst = 1'b0;

        wait_pulse(n);
        wait_pulse(n);
        check(n == 1000, "R6 period after reset", n, 1000);

        for (int i = 0; i < N_VEC; i++) begin
            apply_load(VEC_RATIO[i]);
            wait_pulse(n);
            check(n == prev_n - 2, "R5 cycle in progress keeps old ratio", n, prev_n - 2);
            wait_pulse(n);
            if (VEC_RATIO[i] < 15'd240)
                check(n == VEC_EXP[i], "R2 low ratio clamped", n, VEC_EXP[i]);
            else
                check(n == VEC_EXP[i], "R1 period equals 16M+A", n, VEC_EXP[i]);
            prev_n = VEC_EXP[i];
        end

        // R7: two loads inside one output cycle; the later one wins.
        @(negedge clk);
        check(div_pulse == 1'b0, "R3 pulse one cycle wide", int'(div_pulse), 0);
        ratio_in = 15'd500;
        ratio_load = 1'b1;
        @(negedge clk);
        ratio_in = 15'd3000;
        @(negedge clk);
        ratio_load = 1'b0;
        wait_pulse(n);
        check(n == prev_n - 3, "R7 old ratio kept before double load applies", n, prev_n - 3);
        wait_pulse(n);
        check(n == 3000, "R7 last load wins", n, 3000);
        prev_n = 3000;

        for (int k = 0; k < 3; k++) begin
            logic [14:0] r;
            r = 15'($urandom_range(4000, 240));
            e = model_period(r);
            apply_load(r);
            wait_pulse(n);
            check(n == prev_n - 2, "R5 random update boundary", n, prev_n - 2);
            wait_pulse(n);
            check(n == e, "R1 random ratio period", n, e);
            prev_n = e;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule